// File: doc/BRIEF.md
# Scan-Controlled Bus Test Engine

This block is a test data register that sits on a serial scan chain and steers a small test datapath on an 8-bit bus. An 11-bit control word is scanned in through the chain. The word holds eight per-input mask bits and a 3-bit opcode. While the run-test instruction is active, each run-test strobe moves an 8-bit pattern register forward by one step. The step depends on the opcode: it generates a pseudo-random pattern, compresses the masked bus inputs into a signature, or counts up in binary.

The serial stage and the active control word are separate registers. Scanning a new word therefore leaves the running operation untouched until the update strobe copies it across. In the capture state, the serial stage takes a copy of the active word, so the word can be read back on TDO without being changed. The TAP state machine, the instruction decode and any boundary cells live outside this block. The block sees them only as synchronous strobes and a test-logic-reset level.

Top module: `bus_test_engine`

## Requirements
- R1: After the asynchronous reset, the active control word is 11'b000_0000_0010 (signature mode, no mask), and the pattern register holds RESET_PAT (default 8'h01).
- R2: A cycle with `tlr` high returns the control word to 11'b000_0000_0010 and the pattern register to RESET_PAT. This takes priority over every strobe.
- R3: During `shift_dr`, `tdi` enters at control bit 10 and each bit moves one place toward bit 0. `tdo` always shows bit 0 of the serial stage. As a result, a word sent least-significant bit first is in place after 11 shifts.
- R4: The active control word changes only on an `update_dr` cycle, where it takes the serial stage. Shift and capture cycles leave the running operation unchanged.
- R5: `capture_dr` loads the serial stage from the active word and does not alter the active word. Scanning it out on `tdo` therefore returns the current control word.
- R6: Opcode field bits [2:0] = 3'b010 selects signature analysis. A step computes next = {p[6:0], p[7]^p[5]^p[4]^p[3]} XOR masked(bus_in), which is the polynomial x^8+x^6+x^5+x^4+1.
- R7: Control bit 3+i is the mask for `bus_in[i]`. A 1 forces that input to 0 before the XOR. A 0 passes the input through.
- R8: Opcode 3'b001 selects pattern generation: a step applies the same LFSR shift with no input.
- R9: Opcode 3'b011 adds one to the pattern register on each step, modulo 256 (8'hFF goes to 8'h00).
- R10: Opcodes 3'b000 and 3'b100 to 3'b111 hold the pattern register on a step.
- R11: The pattern register changes only in a cycle where both `run_en` and `run_step` are high, or on reset or `tlr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tlr | input | 1 | Test-logic-reset state indication |
| tdi | input | 1 | Serial scan data in |
| capture_dr | input | 1 | Capture strobe for this data register |
| shift_dr | input | 1 | Shift strobe for this data register |
| update_dr | input | 1 | Update strobe for this data register |
| tdo | output | 1 | Serial scan data out |
| run_en | input | 1 | Run-test instruction is active |
| run_step | input | 1 | Advance the selected operation by one step |
| bus_in | input | 8 | Bus inputs to be compressed |
| pattern | output | 8 | Pattern / signature / count register |

## Verification
The hardest case to reach from the ports is a running operation that keeps advancing while a different control word is partly shifted in. That case requires run strobes and scan shifts in the same cycles. It also requires the effect of the new opcode to appear only after the update cycle. The stimulus reaches it in two ways: a directed scan that steps a count on every shift cycle, and a randomized mix that interleaves scans, run strobes and test-logic-reset. A directed run up to 8'hFF exercises the count wrap. A fully masked signature driven with all-ones inputs separates the masking behaviour from plain pattern generation.

// File: rtl/bte_pkg.sv
package bte_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_HOLD  = 3'b000,
    OP_PRPG  = 3'b001,
    OP_SIG   = 3'b010,
    OP_COUNT = 3'b011
  } op_e;
endpackage

// File: rtl/bte_ctrl_reg.sv
module bte_ctrl_reg #(
  parameter int          W        = 11,
  parameter logic [W-1:0] RST_WORD = 11'b000_0000_0010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tlr,
  input  logic         tdi,
  input  logic         capture_dr,
  input  logic         shift_dr,
  input  logic         update_dr,
  output logic         tdo,
  output logic [W-1:0] shift_word,
  output logic [W-1:0] ctrl_word
);
  logic [W-1:0] sh_q, sh_d, ctrl_q, ctrl_d;
  logic         sh_en, ctrl_en;

  // serial stage next state
  always_comb begin
    sh_en = tlr | capture_dr | shift_dr;
    sh_d  = sh_q;
    if (tlr)             sh_d = RST_WORD;
    else if (capture_dr) sh_d = ctrl_q;
    else if (shift_dr)   sh_d = {tdi, sh_q[W-1:1]};
  end

  // active word next state
  always_comb begin
    ctrl_en = tlr | update_dr;
    ctrl_d  = tlr ? RST_WORD : sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= RST_WORD;
      ctrl_q <= RST_WORD;
    end else begin
      if (sh_en)   sh_q   <= sh_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end

  assign tdo        = sh_q[0];
  assign shift_word = sh_q;
  assign ctrl_word  = ctrl_q;
endmodule

// File: rtl/bte_engine.sv
module bte_engine
  import bte_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] TAPS      = 8'hB8,
  parameter logic [DATA_W-1:0] RESET_PAT = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tlr,
  input  logic              step,
  input  op_e               op,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] pattern
);
  logic [DATA_W-1:0] pat_q, pat_d, shifted, gated;
  logic              fb, pat_en;

  always_comb begin
    fb      = ^(pat_q & TAPS);
    shifted = {pat_q[DATA_W-2:0], fb};
    gated   = bus_in & ~mask;
  end

  always_comb begin
    pat_d = pat_q;
    unique case (op)
      OP_PRPG:  pat_d = shifted;
      OP_SIG:   pat_d = shifted ^ gated;
      OP_COUNT: pat_d = pat_q + 1'b1;
      default:  pat_d = pat_q;
    endcase
    if (tlr) pat_d = RESET_PAT;
    pat_en = tlr | step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pat_q <= RESET_PAT;
    else if (pat_en) pat_q <= pat_d;
  end

  assign pattern = pat_q;
endmodule

// File: rtl/bus_test_engine.sv
module bus_test_engine
  import bte_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] TAPS      = 8'hB8,
  parameter logic [DATA_W-1:0] RESET_PAT = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tlr,
  input  logic              tdi,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  output logic              tdo,
  input  logic              run_en,
  input  logic              run_step,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] pattern
);
  localparam int                CTRL_W   = DATA_W + OP_W;
  localparam logic [CTRL_W-1:0] RST_WORD = CTRL_W'({OP_SIG});

  logic [CTRL_W-1:0] ctrl_word, shift_word;
  logic              step;

  bte_ctrl_reg #(.W(CTRL_W), .RST_WORD(RST_WORD)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tlr        (tlr),
    .tdi        (tdi),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .tdo        (tdo),
    .shift_word (shift_word),
    .ctrl_word  (ctrl_word)
  );

  assign step = run_en & run_step;

  bte_engine #(.DATA_W(DATA_W), .TAPS(TAPS), .RESET_PAT(RESET_PAT)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .tlr     (tlr),
    .step    (step),
    .op      (op_e'(ctrl_word[OP_W-1:0])),
    .mask    (ctrl_word[CTRL_W-1:OP_W]),
    .bus_in  (bus_in),
    .pattern (pattern)
  );
endmodule

// File: rtl/bus_test_engine_chk.sv
module bus_test_engine_chk #(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] RESET_PAT = 8'h01
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tlr,
  input logic              update_dr,
  input logic              run_en,
  input logic              run_step,
  input logic [DATA_W+2:0] ctrl_word,
  input logic [DATA_W+2:0] shift_word,
  input logic [DATA_W-1:0] pattern
);
  // R2
  tlr_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlr |=> (ctrl_word == 11'b000_0000_0010) && (pattern == RESET_PAT));

  // R4
  ctrl_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tlr && !update_dr) |=> $stable(ctrl_word));

  // R4
  ctrl_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tlr && update_dr) |=> ctrl_word == $past(shift_word));

  // R11
  pat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tlr && !(run_en && run_step)) |=> $stable(pattern));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tlr && run_en && run_step && ctrl_word[2:0] == 3'b011)
      |=> pattern == $past(pattern) + 8'd1);

  // R10
  hold_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tlr && (ctrl_word[2:0] == 3'b000 || ctrl_word[2])) |=> $stable(pattern));
endmodule

bind bus_test_engine bus_test_engine_chk #(.DATA_W(DATA_W), .RESET_PAT(RESET_PAT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tlr        (tlr),
  .update_dr  (update_dr),
  .run_en     (run_en),
  .run_step   (run_step),
  .ctrl_word  (ctrl_word),
  .shift_word (shift_word),
  .pattern    (pattern)
);

// File: tb/tb_bus_test_engine.sv
module tb_bus_test_engine;
  localparam logic [7:0]  RST_PAT = 8'h01;
  localparam logic [10:0] RST_CW  = 11'b000_0000_0010;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tlr = 1'b0, tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
  logic       run_en = 1'b0, run_step = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic       tdo;
  logic [7:0] pattern;

  int tests = 0, fails = 0;
  logic [10:0] exp_ctrl;
  logic [7:0]  exp_pat;
  logic [31:0] seed = 32'h1234_5678;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  bus_test_engine dut (
    .clk(clk), .rst_n(rst_n), .tlr(tlr), .tdi(tdi), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdo(tdo), .run_en(run_en),
    .run_step(run_step), .bus_in(bus_in), .pattern(pattern)
  );

  function automatic logic [7:0] model_step(logic [7:0] p, logic [10:0] cw, logic [7:0] b);
    logic [7:0] sh;
    sh = {p[6:0], p[7] ^ p[5] ^ p[4] ^ p[3]};
    case (cw[2:0])
      3'b001:  return sh;
      3'b010:  return sh ^ (b & ~cw[10:3]);
      3'b011:  return p + 8'd1;
      default: return p;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock edge; model the pattern and compare it
  task automatic tick(string req);
    logic [7:0] e;
    e = exp_pat;
    if (tlr) e = RST_PAT;
    else if (run_en && run_step) e = model_step(exp_pat, exp_ctrl, bus_in);
    @(posedge clk); #1;
    exp_pat = e;
    if (tlr) exp_ctrl = RST_CW;
    chk(pattern == exp_pat, req, pattern, exp_pat);
  endtask

  // capture, exchange 11 bits LSB first, optional update
  task automatic scan(logic [10:0] wr, bit upd, bit step_each, output logic [10:0] rd);
    run_step = 1'b0;
    capture_dr = 1'b1;
    tick("R5");
    capture_dr = 1'b0;
    shift_dr = 1'b1;
    for (int i = 0; i < 11; i++) begin
      rd[i] = tdo;
      tdi = wr[i];
      if (step_each) begin
        run_en = 1'b1; run_step = 1'b1; bus_in = 8'($urandom);
      end
      tick("R4");
    end
    shift_dr = 1'b0;
    run_step = 1'b0;
    chk(rd == exp_ctrl, "R3 R5 readback", rd, exp_ctrl);
    if (upd) begin
      update_dr = 1'b1;
      tick("R4");
      update_dr = 1'b0;
      exp_ctrl = wr;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [10:0] rd;
    void'($urandom(seed));
    exp_ctrl = RST_CW;
    exp_pat  = RST_PAT;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(pattern == RST_PAT, "R1 pattern", pattern, RST_PAT);
    rst_n = 1'b1;
    @(posedge clk); #1;
    scan(11'h000, 1'b0, 1'b0, rd);  // R1 readback of control word
    chk(rd == RST_CW, "R1 ctrl", rd, RST_CW);

    // R6 signature, no mask, from reset word
    run_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      bus_in = 8'($urandom); run_step = 1'b1; tick("R6");
    end
    run_step = 1'b0;

    // R7 all inputs masked: same as pure LFSR shift
    scan({8'hFF, 3'b010}, 1'b1, 1'b0, rd);
    bus_in = 8'hFF; run_step = 1'b1;
    begin
      logic [7:0] p0;
      p0 = pattern;
      tick("R7");
      chk(pattern == {p0[6:0], p0[7]^p0[5]^p0[4]^p0[3]}, "R7 full mask", pattern,
          {p0[6:0], p0[7]^p0[5]^p0[4]^p0[3]});
    end
    // R7 single mask bit 3 masks bus_in[0]
    scan({8'h01, 3'b010}, 1'b1, 1'b0, rd);
    bus_in = 8'h01; run_step = 1'b1;
    tick("R7 mask bit3");
    bus_in = 8'h02; tick("R7 unmasked input1");
    run_step = 1'b0;

    // R8 pattern generation
    scan(11'b000_0000_0001, 1'b1, 1'b0, rd);
    run_step = 1'b1;
    for (int i = 0; i < 8; i++) begin
      bus_in = 8'($urandom); tick("R8");
    end

    // R9 count with wrap
    scan(11'b000_0000_0011, 1'b1, 1'b0, rd);
    run_step = 1'b1;
    while (exp_pat != 8'hFF) tick("R9");
    tick("R9 wrap");
    chk(pattern == 8'h00, "R9 wrap", pattern, 8'h00);

    // R4: count keeps running while a hold word is shifted in
    scan(11'b000_0000_0000, 1'b1, 1'b1, rd);
    // R10 hold codes
    run_step = 1'b1;
    tick("R10 op000");
    scan({8'h5A, 3'b110}, 1'b1, 1'b0, rd);
    run_step = 1'b1;
    tick("R10 op110");
    run_step = 1'b0;

    // R11 strobe without run_en
    scan(11'b000_0000_0011, 1'b1, 1'b0, rd);
    run_en = 1'b0; run_step = 1'b1;
    tick("R11");
    run_en = 1'b1; run_step = 1'b0;
    tick("R11");

    // R2 test-logic-reset over an update
    tdi = 1'b1; shift_dr = 1'b1; tick("R3"); shift_dr = 1'b0;
    tlr = 1'b1; update_dr = 1'b1; run_step = 1'b1;
    tick("R2");
    tlr = 1'b0; update_dr = 1'b0; run_step = 1'b0;
    scan(11'h000, 1'b0, 1'b0, rd);
    chk(rd == RST_CW, "R2 ctrl", rd, RST_CW);

    // randomized mix
    for (int it = 0; it < 400; it++) begin
      int sel;
      sel = int'($urandom_range(0, 19));
      if (sel < 6) begin
        scan(11'($urandom), 1'($urandom), 1'($urandom), rd);
      end else if (sel == 6) begin
        tlr = 1'b1; tick("R2"); tlr = 1'b0;
      end else begin
        for (int k = 0; k < 6; k++) begin
          run_en = 1'($urandom); run_step = 1'($urandom); bus_in = 8'($urandom);
          tick("R6 R8 R9 R10 R11 random");
        end
        run_step = 1'b0;
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule